// File: doc/BRIEF.md
# Programmable Chip-Select and Wait-State Decoder

This block sits between the bus master and external memories and peripherals. It compares the top byte of a 24-bit address against four programmable regions. For each access it drives at most one active-low chip select and reports whether the access uses a 16-bit or an 8-bit data path. It also holds the access open for a programmed number of wait cycles before it signals completion. An address that falls in no enabled region still completes, using a separate set of width and wait settings for the default region.

Each region has three 8-bit registers. The base register holds address bits 23..16 of the region's base. In the mask register, each set bit removes one of those address bits from the compare, so a region covers a power-of-two number of 64-Kbyte blocks. The control register holds an enable bit, a width bit and a 3-bit wait count.

The decoder samples the selection and the settings on the cycle an access starts. The access then runs to completion with those values, even if the registers change part-way through.

Top module: `cs_wait_decoder`

## Requirements
- R1: After reset every chip select is high and `bus_ready` is low. All regions are disabled, and the default region uses 16-bit width with 7 wait cycles.
- R2: The register address is {group, index}, with the group in the top two bits and the region index in the low two bits. Group 0 is the base, group 1 is the mask, group 2 is region control, and group 3 with index 0 (address 12) is default-region control. A write to address 13, 14 or 15 changes nothing. In a control byte, bit 7 is enable (ignored for the default region), bit 3 is width (1 = 16-bit) and bits 2..0 are the wait count.
- R3: An enabled region matches when, for every bit k from 0 to 7 whose mask bit is clear, address bit 16+k equals base bit k.
- R4: A region whose enable bit is 0 never matches, and its chip select stays high.
- R5: When several enabled regions match, only the lowest-numbered one is selected.
- R6: At no time is more than one bit of `cs_n` low.
- R7: During an access, `bus_is_16` equals the width bit of the selected region, or the width bit of the default region when no region matches.
- R8: An access accepted at a clock edge keeps its chip select low, and `bus_ready` low, for W cycles after that edge, where W is the wait count. In cycle W+1 `bus_ready` is high. After that cycle the decoder returns to idle, with every chip select high and `bus_ready` low, unless a new access starts.
- R9: A wait count of 0 gives `bus_ready` high in the first cycle of the access.
- R10: A `bus_start` pulse during a cycle in which an access is active and `bus_ready` is low is ignored.
- R11: Register writes made during an access do not change that access's chip select, width or length.
- R12: A `bus_start` in the cycle in which `bus_ready` is high begins the next access at once, with no idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr_en | input | 1 | Register write strobe |
| cfg_wr_addr | input | 4 | Register address {group, index} |
| cfg_wr_data | input | 8 | Register write data |
| bus_start | input | 1 | First cycle of a bus access |
| bus_addr | input | 24 | Access address, valid with `bus_start` |
| cs_n | output | 4 | Active-low chip selects, one per region |
| bus_is_16 | output | 1 | Current access uses the 16-bit path |
| bus_ready | output | 1 | Last cycle of the current access |

## Verification
The hardest situation to reach from the ports is overlapping regions. A lower-numbered region must win over a higher one that also matches, and disabling the winner must hand the address to the next region. The stimulus builds a catch-all region, with every mask bit set, on top of smaller regions. It then probes addresses inside each smaller region, and afterwards disables the catch-all region. Accesses are also started in the ready cycle of the previous one, and register writes and stray start pulses are issued in the middle of long waits. This shows that the settings captured at the start of an access hold until it ends.

// File: rtl/csw_pkg.sv
package csw_pkg;
    localparam int CSW_ADDR_W  = 24;
    localparam int CSW_BASE_W  = 8;
    localparam int CSW_WAIT_W  = 3;
    localparam int CSW_AREAS   = 4;
    localparam int CSW_DATA_W  = 8;

    // control byte layout
    localparam int CTL_EN_BIT   = 7;
    localparam int CTL_WIDE_BIT = 3;

    // register groups (top two bits of the register address)
    localparam logic [1:0] GRP_BASE = 2'd0;
    localparam logic [1:0] GRP_MASK = 2'd1;
    localparam logic [1:0] GRP_CTRL = 2'd2;
    localparam logic [1:0] GRP_DFLT = 2'd3;

    typedef struct packed {
        logic                  en;
        logic                  wide;
        logic [CSW_WAIT_W-1:0] wt;
    } area_cfg_t;
endpackage

// File: rtl/csw_regfile.sv
module csw_regfile
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = CSW_AREAS,
    parameter int BASE_W    = CSW_BASE_W,
    parameter int DATA_W    = CSW_DATA_W,
    parameter int IDX_W     = $clog2(NUM_AREAS),
    parameter int REG_AW    = 2 + IDX_W
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [REG_AW-1:0]                 wr_addr,
    input  logic [DATA_W-1:0]                 wr_data,
    output logic [NUM_AREAS-1:0][BASE_W-1:0]  base_o,
    output logic [NUM_AREAS-1:0][BASE_W-1:0]  mask_o,
    output area_cfg_t [NUM_AREAS-1:0]         area_cfg_o,
    output area_cfg_t                         dflt_cfg_o
);
    typedef struct packed {
        logic [NUM_AREAS-1:0][BASE_W-1:0] base;
        logic [NUM_AREAS-1:0][BASE_W-1:0] mask;
        area_cfg_t [NUM_AREAS-1:0]        cfg;
        area_cfg_t                        dflt;
    } regs_t;

    regs_t regs_d, regs_q;

    logic [1:0]       grp;
    logic [IDX_W-1:0] idx;
    area_cfg_t        wr_cfg;

    assign grp = wr_addr[REG_AW-1 -: 2];
    assign idx = wr_addr[IDX_W-1:0];

    always_comb begin
        wr_cfg.en   = wr_data[CTL_EN_BIT];
        wr_cfg.wide = wr_data[CTL_WIDE_BIT];
        wr_cfg.wt   = wr_data[CSW_WAIT_W-1:0];
    end

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            unique case (grp)
                GRP_BASE: regs_d.base[idx] = wr_data[BASE_W-1:0];
                GRP_MASK: regs_d.mask[idx] = wr_data[BASE_W-1:0];
                GRP_CTRL: regs_d.cfg[idx]  = wr_cfg;
                GRP_DFLT: begin
                    if (idx == '0) begin
                        regs_d.dflt      = wr_cfg;
                        regs_d.dflt.en   = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.base <= '0;
            regs_q.mask <= '0;
            regs_q.cfg  <= '0;
            regs_q.dflt <= '{en: 1'b1, wide: 1'b1, wt: '1};
        end else begin
            regs_q <= regs_d;
        end
    end

    assign base_o     = regs_q.base;
    assign mask_o     = regs_q.mask;
    assign area_cfg_o = regs_q.cfg;
    assign dflt_cfg_o = regs_q.dflt;

    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_CTRL) |=>
            (regs_q.cfg[$past(idx)].en == $past(wr_data[CTL_EN_BIT]))
         && (regs_q.cfg[$past(idx)].wt == $past(wr_data[CSW_WAIT_W-1:0]))); // R2

    AST_SPARE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && grp == GRP_DFLT && idx != '0) |=> $stable(regs_q)); // R2
endmodule

// File: rtl/csw_area_match.sv
module csw_area_match
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = CSW_AREAS,
    parameter int BASE_W    = CSW_BASE_W
) (
    input  logic [BASE_W-1:0]                 addr_hi,
    input  logic [NUM_AREAS-1:0][BASE_W-1:0]  base_i,
    input  logic [NUM_AREAS-1:0][BASE_W-1:0]  mask_i,
    input  area_cfg_t [NUM_AREAS-1:0]         area_cfg_i,
    input  area_cfg_t                         dflt_cfg_i,
    output logic [NUM_AREAS-1:0]              sel_o,
    output area_cfg_t                         sel_cfg_o
);
    logic [NUM_AREAS-1:0] hit;

    for (genvar g = 0; g < NUM_AREAS; g++) begin : g_cmp
        assign hit[g] = area_cfg_i[g].en
                     && (((addr_hi ^ base_i[g]) & ~mask_i[g]) == '0);
    end

    // fixed priority: lowest index wins
    always_comb begin
        sel_o     = '0;
        sel_cfg_o = dflt_cfg_i;
        for (int i = NUM_AREAS - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_o     = '0;
                sel_o[i]  = 1'b1;
                sel_cfg_o = area_cfg_i[i];
            end
        end
    end
endmodule

// File: rtl/csw_wait_seq.sv
module csw_wait_seq
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = CSW_AREAS,
    parameter int WAIT_W    = CSW_WAIT_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [NUM_AREAS-1:0] sel_i,
    input  area_cfg_t            sel_cfg_i,
    output logic [NUM_AREAS-1:0] cs_n_o,
    output logic                 wide_o,
    output logic                 ready_o
);
    typedef struct packed {
        logic                 busy;
        logic [WAIT_W-1:0]    cnt;
        logic [NUM_AREAS-1:0] sel;
        logic                 wide;
    } seq_t;

    seq_t seq_d, seq_q;
    logic last_cyc;
    logic accept;

    assign last_cyc = seq_q.busy && (seq_q.cnt == '0);
    assign accept   = start_i && (!seq_q.busy || last_cyc);

    always_comb begin
        seq_d = seq_q;
        if (seq_q.busy && seq_q.cnt != '0) begin
            seq_d.cnt = seq_q.cnt - 1'b1;
        end else if (seq_q.busy) begin
            seq_d.busy = 1'b0;
            seq_d.sel  = '0;
            seq_d.wide = 1'b0;
        end
        if (accept) begin
            seq_d.busy = 1'b1;
            seq_d.cnt  = sel_cfg_i.wt;
            seq_d.sel  = sel_i;
            seq_d.wide = sel_cfg_i.wide;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '0;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign cs_n_o  = ~seq_q.sel;
    assign wide_o  = seq_q.wide;
    assign ready_o = last_cyc;

    AST_ONE_CS: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n_o)); // R6

    AST_HOLD_IN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && !ready_o) |=> ($stable(cs_n_o) && $stable(wide_o) && seq_q.busy)); // R8

    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.busy && !ready_o) |=> (seq_q.cnt == WAIT_W'($past(seq_q.cnt) - 1'b1))); // R8

    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_o && !start_i) |=> (!ready_o && cs_n_o == '1 && !seq_q.busy)); // R8

    AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && (!seq_q.busy || ready_o)) |=> (seq_q.busy && seq_q.cnt == $past(sel_cfg_i.wt))); // R12

    AST_STRAY_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && seq_q.busy && !ready_o) |=> $stable(cs_n_o)); // R10
endmodule

// File: rtl/cs_wait_decoder.sv
module cs_wait_decoder
    import csw_pkg::*;
#(
    parameter int NUM_AREAS = CSW_AREAS,
    parameter int ADDR_W    = CSW_ADDR_W,
    parameter int BASE_W    = CSW_BASE_W,
    parameter int DATA_W    = CSW_DATA_W,
    parameter int REG_AW    = 2 + $clog2(NUM_AREAS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_wr_en,
    input  logic [REG_AW-1:0]    cfg_wr_addr,
    input  logic [DATA_W-1:0]    cfg_wr_data,
    input  logic                 bus_start,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [NUM_AREAS-1:0] cs_n,
    output logic                 bus_is_16,
    output logic                 bus_ready
);
    localparam int IDX_W = $clog2(NUM_AREAS);

    logic [NUM_AREAS-1:0][BASE_W-1:0] base_w;
    logic [NUM_AREAS-1:0][BASE_W-1:0] mask_w;
    area_cfg_t [NUM_AREAS-1:0]        area_cfg_w;
    area_cfg_t                        dflt_cfg_w;
    logic [NUM_AREAS-1:0]             sel_w;
    area_cfg_t                        sel_cfg_w;

    csw_regfile #(
        .NUM_AREAS (NUM_AREAS),
        .BASE_W    (BASE_W),
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .REG_AW    (REG_AW)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_addr    (cfg_wr_addr),
        .wr_data    (cfg_wr_data),
        .base_o     (base_w),
        .mask_o     (mask_w),
        .area_cfg_o (area_cfg_w),
        .dflt_cfg_o (dflt_cfg_w)
    );

    csw_area_match #(
        .NUM_AREAS (NUM_AREAS),
        .BASE_W    (BASE_W)
    ) u_match (
        .addr_hi    (bus_addr[ADDR_W-1 -: BASE_W]),
        .base_i     (base_w),
        .mask_i     (mask_w),
        .area_cfg_i (area_cfg_w),
        .dflt_cfg_i (dflt_cfg_w),
        .sel_o      (sel_w),
        .sel_cfg_o  (sel_cfg_w)
    );

    csw_wait_seq #(
        .NUM_AREAS (NUM_AREAS),
        .WAIT_W    (CSW_WAIT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (bus_start),
        .sel_i     (sel_w),
        .sel_cfg_i (sel_cfg_w),
        .cs_n_o    (cs_n),
        .wide_o    (bus_is_16),
        .ready_o   (bus_ready)
    );

    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_start && area_cfg_w[0].en == 1'b0 && cs_n[0] == 1'b1 && !bus_ready && cs_n == '1)
            |=> cs_n[0]); // R4
endmodule

// File: tb/cs_wait_decoder_tb.sv
module cs_wait_decoder_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [3:0]  cfg_wr_addr = '0;
    logic [7:0]  cfg_wr_data = '0;
    logic        bus_start = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [3:0]  cs_n;
    logic        bus_is_16;
    logic        bus_ready;

    always #(CLK_PERIOD/2) clk = ~clk;

    cs_wait_decoder u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_addr (cfg_wr_addr),
        .cfg_wr_data (cfg_wr_data),
        .bus_start   (bus_start),
        .bus_addr    (bus_addr),
        .cs_n        (cs_n),
        .bus_is_16   (bus_is_16),
        .bus_ready   (bus_ready)
    );

    typedef struct {
        logic [3:0] cs_n;
        logic       w16;
        int         wt;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    int   pushed = 0;
    int   done   = 0;
    bit   finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cfg_wr_en   = 1'b1;
        cfg_wr_addr = a;
        cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // driver: pushes the expected result, then pulses start for one cycle
    task automatic start_acc(input logic [23:0] a, input logic [3:0] ecs,
                             input logic ew16, input int ewt, input string tag);
        exp_t e;
        e.cs_n = ecs; e.w16 = ew16; e.wt = ewt; e.tag = tag;
        exp_q.push_back(e);
        pushed++;
        bus_addr  = a;
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
    endtask

    task automatic wait_done();
        while (done != pushed) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic acc(input logic [23:0] a, input logic [3:0] ecs,
                       input logic ew16, input int ewt, input string tag);
        start_acc(a, ecs, ew16, ewt, tag);
        wait_done();
    endtask

    // monitor: samples after each falling edge and compares against the queue
    initial begin
        exp_t cur;
        bit   active = 1'b0;
        int   cyc = 0;
        forever begin
            @(negedge clk);
            #1;
            if (!rst_n) continue;
            chk($onehot0(~cs_n), "R6", int'(cs_n), 0);
            if (active) begin
                cyc++;
                chk(cs_n == cur.cs_n, cur.tag, int'(cs_n), int'(cur.cs_n));
                chk(bus_is_16 == cur.w16, {cur.tag, " R7"}, int'(bus_is_16), int'(cur.w16));
                if (bus_ready) begin
                    chk(cyc == cur.wt + 1, {cur.tag, " R8"}, cyc, cur.wt + 1);
                    active = 1'b0;
                    done++;
                end else if (cyc > cur.wt) begin
                    chk(1'b0, {cur.tag, " R8"}, cyc, cur.wt + 1);
                    active = 1'b0;
                    done++;
                end
            end else begin
                chk(cs_n == 4'hF && !bus_ready, "R8 idle",
                    int'({bus_ready, cs_n}), 32'hF);
            end
            if (!active && bus_start) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10 unexpected start", 1, 0);
                end else begin
                    cur    = exp_q.pop_front();
                    active = 1'b1;
                    cyc    = 0;
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            chk(1'b0, "watchdog", 0, 1);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cs_n == 4'hF, "R1 reset cs", int'(cs_n), 32'hF);
        chk(bus_ready == 1'b0, "R1 reset ready", int'(bus_ready), 0);
        @(negedge clk);

        // R1: default region after reset: 16-bit, 7 waits
        acc(24'h123456, 4'hF, 1'b1, 7, "R1");

        // R4: region 0 programmed but not enabled
        wr(4'd0, 8'h01);
        wr(4'd4, 8'h00);
        acc(24'h010000, 4'hF, 1'b1, 7, "R4");

        // R3: region 0 enabled, 16-bit, wait 2 -> 010000..01FFFF
        wr(4'd8, 8'h8A);
        acc(24'h01FFFF, 4'hE, 1'b1, 2, "R3");
        acc(24'h020000, 4'hF, 1'b1, 7, "R3 above");
        acc(24'h00FFFF, 4'hF, 1'b1, 7, "R3 below");

        // R2/R7: default region becomes 8-bit, wait 1
        wr(4'd12, 8'h01);
        acc(24'h020000, 4'hF, 1'b0, 1, "R2 R7");
        // R2: spare address changes nothing
        wr(4'd13, 8'h0F);
        acc(24'hC00000, 4'hF, 1'b0, 1, "R2 spare");

        // R3/R9: region 1, masked low nibble -> 400000..4FFFFF, 8-bit, wait 0
        wr(4'd1, 8'h40);
        wr(4'd5, 8'h0F);
        wr(4'd9, 8'h80);
        acc(24'h4A1234, 4'hD, 1'b0, 0, "R3 R9");
        acc(24'h503000, 4'hF, 1'b0, 1, "R3 mask edge");

        // R5: region 2 covers everything, 16-bit, wait 3
        wr(4'd2, 8'h00);
        wr(4'd6, 8'hFF);
        wr(4'd10, 8'h8B);
        acc(24'h010000, 4'hE, 1'b1, 2, "R5 area0 wins");
        acc(24'h4A0000, 4'hD, 1'b0, 0, "R5 area1 wins");
        acc(24'h800000, 4'hB, 1'b1, 3, "R5 area2");

        // R5: region 3 at 80xxxx loses to region 2
        wr(4'd3, 8'h80);
        wr(4'd7, 8'h00);
        wr(4'd11, 8'h84);
        acc(24'h80FFFF, 4'hB, 1'b1, 3, "R5 area2 over 3");
        // R4: disabling region 2 hands the address to region 3
        wr(4'd10, 8'h00);
        acc(24'h80FFFF, 4'h7, 1'b0, 4, "R4 R5 area3");

        // R10: stray start during wait is ignored
        start_acc(24'h800000, 4'h7, 1'b0, 4, "R10");
        @(negedge clk);
        bus_addr  = 24'h4A0000;
        bus_start = 1'b1;
        @(negedge clk);
        bus_start = 1'b0;
        wait_done();

        // R11: reprogramming during an access does not affect it
        start_acc(24'h800000, 4'h7, 1'b0, 4, "R11");
        wr(4'd11, 8'h88);
        wait_done();
        acc(24'h800000, 4'h7, 1'b1, 0, "R11 after");

        // R12: back-to-back accesses started in the ready cycle
        start_acc(24'h010000, 4'hE, 1'b1, 2, "R12 a");
        repeat (2) @(negedge clk);
        start_acc(24'h4A0000, 4'hD, 1'b0, 0, "R12 b");
        start_acc(24'h800000, 4'h7, 1'b1, 0, "R12 c");
        start_acc(24'hC00000, 4'hF, 1'b0, 1, "R12 d");
        wait_done();

        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R12 queue empty", exp_q.size(), 0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule